// File: doc/BRIEF.md
# External Interrupt Sense Controller

The block samples eight external interrupt pins and one non-maskable interrupt pin. Each pin passes through a two-flop synchroniser and then goes to a detector whose sense mode is programmable. When a qualifying event is seen, the detector latches a pending flag. Each pending flag drives one request line to a parent interrupt controller, which handles priority, masking and vectoring.

Software uses three 16-bit registers over a small register bus. The bus has a byte address, a read strobe, a write strobe, write data and combinational read data.

- The sense register gives each line a 2-bit mode.
- The request register holds the eight pending flags.
- The NMI control register shows the live NMI pin level, holds the NMI edge choice and holds the NMI pending flag.

A pending flag is cleared by writing 0 to it, but only after software has read it as 1. This keeps software from discarding an event it has not yet seen.

Top module: `pin_sense_ctrl`

## Requirements
- R1: Eight lines, numbered 0 to 7. The sense register is at byte offset 2, and line n owns bits [2n+1:2n]. Writes to this register read back unchanged.
- R2: Sense code 0 is low level. While the synchronised pin is low, the line's flag is set on every clock, so a clear cannot hold while the pin stays low.
- R3: Sense code 1 sets the line's flag on a falling edge. A pin that stays steady or rises does not set it.
- R4: Sense code 2 sets the flag on a rising edge. Sense code 3 sets it on either edge.
- R5: The request register is at byte offset 4, and bit n is line n's flag. A set flag stays set until it is cleared. Writing 1 to a bit has no effect, and `irq_req[n]` always equals flag n.
- R6: Writing 0 to a flag clears it only if a read of the request register returned that bit as 1 since the last write to the request register. Otherwise the write leaves the flag unchanged.
- R7: If a new event on a line falls in the same clock as a valid clear of that line, the flag stays set.
- R8: The NMI control register is at byte offset 0. Bit 15 reads the synchronised NMI pin level (1 = high) and ignores writes. Bit 8 selects the NMI edge (0 = falling, 1 = rising). Bit 1 is the NMI flag. The NMI flag follows the same read-then-write-0 clear rule through this register, and `nmi_req` equals it.
- R9: After reset, every sense field is 0, every flag is 0 and the NMI edge select is 0.
- R10: A pin change made between two clock edges shows on its request output after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin | input | 8 | External interrupt pins, asynchronous |
| nmi_pin | input | 1 | Non-maskable interrupt pin, asynchronous |
| reg_addr | input | 3 | Register byte address (0, 2 or 4) |
| reg_rd | input | 1 | Read strobe, arms the clear of flags read as 1 |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from the address |
| irq_req | output | 8 | Request line per external pin |
| nmi_req | output | 1 | NMI request line |

## Verification
A pin edge takes three rising clock edges to reach a request output: two synchroniser flops, then the flag register. The bench changes pins on a falling clock edge and checks for no request after two rising edges and a request after three. Register writes take effect on the next rising edge. Read data is combinational, so the bench samples it shortly after driving the address. For the set-versus-clear case, the bench lines up the write strobe with the third rising edge after a pin toggle, so the event and the clear arrive in the same clock.

// File: rtl/pin_sense_pkg.sv
package pin_sense_pkg;
    typedef enum logic [1:0] {
        SNS_LOW  = 2'd0,
        SNS_FALL = 2'd1,
        SNS_RISE = 2'd2,
        SNS_BOTH = 2'd3
    } sense_t;

    localparam int REG_W      = 16;
    localparam int ADDR_W     = 3;
    localparam logic [ADDR_W-1:0] A_NMI   = 3'd0;
    localparam logic [ADDR_W-1:0] A_SENSE = 3'd2;
    localparam logic [ADDR_W-1:0] A_REQ   = 3'd4;
    localparam int NMI_LVL_BIT  = 15;
    localparam int NMI_EDGE_BIT = 8;
    localparam int NMI_FLAG_BIT = 1;
endpackage

// File: rtl/pin_sync2.sv
module pin_sync2 #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.meta   <= RST_VAL;
            st_q.stable <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/pin_sense_line.sv
module pin_sense_line
    import pin_sense_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sync_i,
    input  sense_t mode_i,
    input  logic   clr_i,
    output logic   flag_o
);
    typedef struct packed {
        logic prev;
        logic flag;
    } line_st_t;

    line_st_t st_d, st_q;
    logic     fall, rise, evt;

    always_comb begin
        fall = st_q.prev & ~sync_i;
        rise = ~st_q.prev & sync_i;
        unique case (mode_i)
            SNS_LOW:  evt = ~sync_i;
            SNS_FALL: evt = fall;
            SNS_RISE: evt = rise;
            default:  evt = fall | rise;
        endcase
        st_d.prev = sync_i;
        st_d.flag = evt | (st_q.flag & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SNS_LOW && !sync_i) |=> flag_o); // R2
    AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SNS_FALL && st_q.prev && !sync_i) |=> flag_o); // R3
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SNS_RISE && !st_q.prev && sync_i) |=> flag_o); // R4
    AST_HOLD_UNTIL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o); // R5
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && mode_i == SNS_LOW && !sync_i) |=> flag_o); // R7
endmodule

// File: rtl/pin_sense_ctrl.sv
module pin_sense_ctrl
    import pin_sense_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        irq_pin,
    input  logic              nmi_pin,
    input  logic [2:0]        reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic [7:0]        irq_req,
    output logic              nmi_req
);
    localparam int SNS_W = 2 * NUM_LINES;

    typedef struct packed {
        logic [SNS_W-1:0]     sense;
        logic                 nmi_edge;
        logic [NUM_LINES-1:0] arm;
        logic                 nmi_arm;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NUM_LINES-1:0] pin_sync, flags, clr;
    logic                 nmi_sync, nmi_flag, nmi_clr;
    logic                 wr_req, rd_req, wr_nmi, rd_nmi, wr_sns;

    assign wr_req = reg_wr && reg_addr == A_REQ;
    assign rd_req = reg_rd && reg_addr == A_REQ;
    assign wr_nmi = reg_wr && reg_addr == A_NMI;
    assign rd_nmi = reg_rd && reg_addr == A_NMI;
    assign wr_sns = reg_wr && reg_addr == A_SENSE;

    pin_sync2 #(.W(NUM_LINES + 1), .RST_VAL('1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({nmi_pin, irq_pin[NUM_LINES-1:0]}),
        .sync_o  ({nmi_sync, pin_sync})
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        assign clr[n] = wr_req && !reg_wdata[n] && regs_q.arm[n];
        pin_sense_line u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_i (pin_sync[n]),
            .mode_i (sense_t'(regs_q.sense[2*n +: 2])),
            .clr_i  (clr[n]),
            .flag_o (flags[n])
        );
    end

    assign nmi_clr = wr_nmi && !reg_wdata[NMI_FLAG_BIT] && regs_q.nmi_arm;

    pin_sense_line u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (nmi_sync),
        .mode_i (regs_q.nmi_edge ? SNS_RISE : SNS_FALL),
        .clr_i  (nmi_clr),
        .flag_o (nmi_flag)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_sns) regs_d.sense = reg_wdata[SNS_W-1:0];
        if (wr_nmi) regs_d.nmi_edge = reg_wdata[NMI_EDGE_BIT];
        if (wr_req)      regs_d.arm = '0;
        else if (rd_req) regs_d.arm = regs_q.arm | flags;
        if (wr_nmi)      regs_d.nmi_arm = 1'b0;
        else if (rd_nmi) regs_d.nmi_arm = regs_q.nmi_arm | nmi_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_NMI: begin
                reg_rdata[NMI_LVL_BIT]  = nmi_sync;
                reg_rdata[NMI_EDGE_BIT] = regs_q.nmi_edge;
                reg_rdata[NMI_FLAG_BIT] = nmi_flag;
            end
            A_SENSE: reg_rdata[SNS_W-1:0]     = regs_q.sense;
            A_REQ:   reg_rdata[NUM_LINES-1:0] = flags;
            default: reg_rdata = '0;
        endcase
    end

    assign irq_req = flags;
    assign nmi_req = nmi_flag;

    AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> ((irq_req & $past(irq_req)) == $past(irq_req))); // R6
    AST_NMI_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !wr_nmi) |=> nmi_req); // R8
    AST_UNARMED_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && regs_q.arm == '0) |=> ((irq_req & $past(irq_req)) == $past(irq_req))); // R6
endmodule

// File: tb/sim_pin_sense_ctrl.sv
module sim_pin_sense_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_pin = 8'hFF;
    logic        nmi_pin = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  irq_req;
    logic        nmi_req;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_sense_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .nmi_pin(nmi_pin),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .nmi_req(nmi_req)
    );

    // entry: [7:5] line, [4:3] sense code, [2] start level, [1] end level, [0] expected flag
    localparam logic [7:0] VEC [10] = '{
        {3'd0, 2'd0, 1'b1, 1'b0, 1'b1},
        {3'd1, 2'd0, 1'b1, 1'b1, 1'b0},
        {3'd2, 2'd1, 1'b1, 1'b0, 1'b1},
        {3'd3, 2'd1, 1'b0, 1'b1, 1'b0},
        {3'd4, 2'd2, 1'b0, 1'b1, 1'b1},
        {3'd5, 2'd2, 1'b1, 1'b0, 1'b0},
        {3'd6, 2'd3, 1'b1, 1'b0, 1'b1},
        {3'd7, 2'd3, 1'b0, 1'b1, 1'b1},
        {3'd0, 2'd1, 1'b1, 1'b1, 1'b0},
        {3'd3, 2'd2, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        logic [15:0] d;
        bus_read(3'd4, d);
        bus_write(3'd4, 16'h0000);
        bus_read(3'd0, d);
        bus_write(3'd0, {7'd0, d[8], 8'd0});
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        settle();

        // R9 reset state
        bus_read(3'd2, d); check("R9 sense reset", d, 16'h0000);
        bus_read(3'd4, d); check("R9 flags reset", d, 16'h0000);
        bus_read(3'd0, d); check("R9 nmi ctrl reset, R8 level high", d, 16'h8000);
        check("R9 outputs", {7'd0, nmi_req, irq_req}, 16'h0000);

        // R1 sense readback
        bus_write(3'd2, 16'hA5C3);
        bus_read(3'd2, d); check("R1 sense readback", d, 16'hA5C3);

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < 10; i++) begin
            logic [2:0] ln;
            logic [7:0] exp;
            ln = VEC[i][7:5];
            irq_pin = 8'hFF;
            settle();
            bus_write(3'd2, 16'(VEC[i][4:3]) << (2 * ln));
            irq_pin[ln] = VEC[i][2];
            settle();
            clear_all();
            settle();
            irq_pin[ln] = VEC[i][1];
            settle();
            exp = 8'(VEC[i][0]) << ln;
            check($sformatf("R2/R3/R4 vec %0d", i), {8'd0, irq_req}, {8'd0, exp});
            bus_read(3'd4, d); check($sformatf("R5 vec %0d readback", i), d, {8'd0, exp});
        end

        // R10 latency, rising mode line 4
        irq_pin = 8'hFF; settle();
        bus_write(3'd2, 16'h0200);
        irq_pin[4] = 1'b0; settle(); clear_all(); settle();
        @(negedge clk) irq_pin[4] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) check("R10 not after two edges", {8'd0, irq_req}, 16'h0000);
        @(posedge clk);
        @(negedge clk) check("R10 set after three edges", {8'd0, irq_req}, 16'h0010);

        // R5 write 1 no effect; R6 write 0 without read no effect
        bus_write(3'd4, 16'h00FF);
        check("R5 write one keeps", {8'd0, irq_req}, 16'h0010);
        bus_write(3'd4, 16'h0000);
        check("R6 unarmed write zero keeps", {8'd0, irq_req}, 16'h0010);
        bus_read(3'd4, d);
        bus_write(3'd4, 16'h00FF);
        bus_write(3'd4, 16'h0000);
        check("R6 write after intervening write keeps", {8'd0, irq_req}, 16'h0010);
        bus_read(3'd4, d);
        bus_write(3'd4, 16'h0000);
        check("R6 read then write zero clears", {8'd0, irq_req}, 16'h0000);

        // R7 event and clear in the same clock (both-edge mode on line 4)
        bus_write(3'd2, 16'h0300);
        @(negedge clk) irq_pin[4] = 1'b0;
        settle();
        bus_read(3'd4, d);
        @(negedge clk) irq_pin[4] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk) begin reg_addr = 3'd4; reg_wdata = 16'h0000; reg_wr = 1'b1; end
        @(negedge clk) reg_wr = 1'b0;
        check("R7 set wins over clear", {8'd0, irq_req}, 16'h0010);

        // R2 level low cannot stay cleared
        bus_write(3'd2, 16'h0000);
        irq_pin[4] = 1'b0; settle();
        bus_read(3'd4, d);
        bus_write(3'd4, 16'h0000);
        check("R2 level low reasserts", {8'd0, irq_req}, 16'h0010);
        irq_pin[4] = 1'b1; settle(); clear_all();
        check("R2 clears once high", {8'd0, irq_req}, 16'h0000);

        // R8 NMI
        bus_write(3'd0, 16'h8000);
        bus_read(3'd0, d); check("R8 level bit ignores write", d, 16'h8000);
        @(negedge clk) nmi_pin = 1'b0;
        settle();
        check("R8 falling nmi", {15'd0, nmi_req}, 16'h0001);
        bus_read(3'd0, d); check("R8 ctrl readback low", d, 16'h0002);
        bus_write(3'd0, 16'h0100);
        check("R8 nmi cleared, edge rising", {15'd0, nmi_req}, 16'h0000);
        bus_read(3'd0, d); check("R8 edge select readback", d, 16'h0100);
        @(negedge clk) nmi_pin = 1'b1;
        settle();
        check("R8 rising nmi", {15'd0, nmi_req}, 16'h0001);
        bus_write(3'd0, 16'h0100);
        check("R8 unarmed nmi write keeps", {15'd0, nmi_req}, 16'h0001);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule